// File: doc/BRIEF.md
# Power Management Event Block

This block gathers the power management events of a system into a status register, masks them with an enable register and drives one level-sensitive system control interrupt (SCI). It also holds a control register and a free-running timer. Software reaches all of them through a small register port decoded on a 4-bit offset. Each status bit is set by hardware and cleared by software. The interrupt stays high for as long as any enabled event bit that the block monitors is pending.

The timer advances once for every cycle in which the tick-enable input is high. The rate of the system clock therefore does not matter. Each time the top bit of the timer changes value, an overflow event is latched into the status register. When software writes the control register with the sleep-enable bit set and a sleep type of zero, the block emits a single-cycle shutdown request.

Top module: `pm_event_block`

## Requirements
- R1: Offsets come from `addr_i`: 0x0 status, 0x2 enable, 0x4 control, 0x8 timer. Any other offset reads as zero, and writes to it change no register. The timer is read-only, so a write at 0x8 has no effect.
- R2: After reset the status, enable and control registers, the timer, `sci_o` and `shutdown_o` are all zero.
- R3: The monitored status bits are: bit 0 timer overflow, bit 5 global lock (`evt_gbl_i`), bit 8 power button (`evt_pwrbtn_i`) and bit 10 real-time clock (`evt_rtc_i`). A high event input sets its bit on that clock edge. If a hardware set and a software clear reach the same bit in the same cycle, the set wins.
- R4: A write to offset 0x0 clears every status bit written as one and leaves every bit written as zero unchanged.
- R5: The enable register stores and reads back all 16 written bits.
- R6: `sci_o` is a register. After each clock edge it equals the OR over bits 0, 5, 8 and 10 (mask 0x0521) of the new status AND the new enable.
- R7: The timer increments by one on each edge where `tick_i` is high and wraps modulo 2^TMR_W. It holds its value otherwise.
- R8: Status bit 0 is set on the edge where the timer's top bit changes value, in either direction.
- R9: Once bit 0 is cleared, it stays clear until the next change of the timer's top bit.
- R10: A write to offset 0x4 stores all bits except bit 13 (sleep enable), which always reads as zero.
- R11: Consider a write to offset 0x4 with bit 13 set and sleep type bits 11:10 equal to 0. `shutdown_o` is high for exactly the cycle after that edge. Any other sleep type, or bit 13 clear, produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timer advance enable |
| evt_gbl_i | input | 1 | Global lock event, sets status bit 5 |
| evt_pwrbtn_i | input | 1 | Power button event, sets status bit 8 |
| evt_rtc_i | input | 1 | Real-time clock event, sets status bit 10 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 16 | Write data |
| rd_data_o | output | TMR_W | Combinational read data for `addr_i` |
| sci_o | output | 1 | Level-sensitive system control interrupt |
| shutdown_o | output | 1 | Single-cycle soft-off request |

## Verification
Register writes, event inputs and ticks take effect on the clock edge that samples them. `sci_o` and `shutdown_o` change on that same edge, because both are registered from next-state values. Read data is combinational and follows `addr_i` and the current register contents with no added latency. The bench drives every input at the falling edge and checks `sci_o` and `shutdown_o` 1 ns after the rising edge. It then places a read offset and compares `rd_data_o` 1 ns later, still before the next rising edge. Overflow is checked with a reduced timer width, both on the exact tick that flips the top bit and with a status clear landing on that same tick.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int REG_W = 16;

    localparam logic [3:0] OFS_STS = 4'h0;
    localparam logic [3:0] OFS_EN  = 4'h2;
    localparam logic [3:0] OFS_CTL = 4'h4;
    localparam logic [3:0] OFS_TMR = 4'h8;

    localparam int BIT_OVF    = 0;
    localparam int BIT_GBL    = 5;
    localparam int BIT_PWR    = 8;
    localparam int BIT_RTC    = 10;
    localparam int BIT_SLP_EN = 13;
    localparam int TYP_LO     = 10;

    localparam logic [1:0] TYP_SOFT_OFF = 2'd0;

    localparam logic [REG_W-1:0] SCI_MASK =
        (REG_W'(1) << BIT_OVF) | (REG_W'(1) << BIT_GBL) |
        (REG_W'(1) << BIT_PWR) | (REG_W'(1) << BIT_RTC);

    localparam logic [REG_W-1:0] SLP_EN_BIT = REG_W'(1) << BIT_SLP_EN;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] ctl;
        logic             sci;
        logic             shutdown;
    } pm_state_t;
endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
    parameter int W = 24
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    output logic [W-1:0] count_o,
    output logic         ovf_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign ovf_o   = cnt_d[W-1] ^ cnt_q[W-1];
endmodule

// File: rtl/pm_sts_next.sv
module pm_sts_next #(
    parameter int W = 16
) (
    input  logic [W-1:0] sts_q_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] sts_d_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sts_d_o[i] = set_i[i] | (sts_q_i[i] & ~clr_i[i]);
    end
endmodule

// File: rtl/pm_read_mux.sv
module pm_read_mux #(
    parameter int RD_W = 24
) (
    input  logic [3:0]                  addr_i,
    input  logic [pm_evt_pkg::REG_W-1:0] sts_i,
    input  logic [pm_evt_pkg::REG_W-1:0] en_i,
    input  logic [pm_evt_pkg::REG_W-1:0] ctl_i,
    input  logic [RD_W-1:0]             tmr_i,
    output logic [RD_W-1:0]             rdata_o
);
    import pm_evt_pkg::*;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_STS: rdata_o = RD_W'(sts_i);
            OFS_EN:  rdata_o = RD_W'(en_i);
            OFS_CTL: rdata_o = RD_W'(ctl_i);
            OFS_TMR: rdata_o = tmr_i;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block #(
    parameter int TMR_W = 24
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         tick_i,
    input  logic                         evt_gbl_i,
    input  logic                         evt_pwrbtn_i,
    input  logic                         evt_rtc_i,
    input  logic                         wr_en_i,
    input  logic [3:0]                   addr_i,
    input  logic [pm_evt_pkg::REG_W-1:0] wdata_i,
    output logic [TMR_W-1:0]             rd_data_o,
    output logic                         sci_o,
    output logic                         shutdown_o
);
    import pm_evt_pkg::*;

    pm_state_t st_d, st_q;

    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_ovf;
    logic             wr_sts, wr_en_reg, wr_ctl;
    logic [REG_W-1:0] sts_clr, sts_set, sts_nxt;

    assign wr_sts    = wr_en_i && (addr_i == OFS_STS);
    assign wr_en_reg = wr_en_i && (addr_i == OFS_EN);
    assign wr_ctl    = wr_en_i && (addr_i == OFS_CTL);

    always_comb begin
        sts_set          = '0;
        sts_set[BIT_OVF] = tmr_ovf;
        sts_set[BIT_GBL] = evt_gbl_i;
        sts_set[BIT_PWR] = evt_pwrbtn_i;
        sts_set[BIT_RTC] = evt_rtc_i;
    end

    assign sts_clr = wr_sts ? wdata_i : '0;

    pm_tick_timer #(.W(TMR_W)) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .count_o (tmr_cnt),
        .ovf_o   (tmr_ovf)
    );

    pm_sts_next #(.W(REG_W)) u_sts (
        .sts_q_i (st_q.sts),
        .clr_i   (sts_clr),
        .set_i   (sts_set),
        .sts_d_o (sts_nxt)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sts      = sts_nxt;
        if (wr_en_reg) st_d.en  = wdata_i;
        if (wr_ctl)    st_d.ctl = wdata_i & ~SLP_EN_BIT;
        st_d.shutdown = wr_ctl && wdata_i[BIT_SLP_EN] &&
                        (wdata_i[TYP_LO+1:TYP_LO] == TYP_SOFT_OFF);
        st_d.sci      = |(st_d.sts & st_d.en & SCI_MASK);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    pm_read_mux #(.RD_W(TMR_W)) u_rd (
        .addr_i  (addr_i),
        .sts_i   (st_q.sts),
        .en_i    (st_q.en),
        .ctl_i   (st_q.ctl),
        .tmr_i   (tmr_cnt),
        .rdata_o (rd_data_o)
    );

    assign sci_o      = st_q.sci;
    assign shutdown_o = st_q.shutdown;
endmodule

// File: rtl/pm_event_block_chk.sv
module pm_event_block_chk #(
    parameter int TMR_W = 24
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             evt_any,
    input logic             wr_en_i,
    input logic [3:0]       addr_i,
    input logic [15:0]      wdata_i,
    input logic             ovf,
    input logic [TMR_W-1:0] tmr,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic [TMR_W-1:0] rd_data_o,
    input logic             sci_o,
    input logic             shutdown_o
);
    // R1
    unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i != 4'h0 && addr_i != 4'h2 && addr_i != 4'h4 && addr_i != 4'h8)
        |-> rd_data_o == '0);

    // R10
    slp_en_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == 4'h4) |-> !rd_data_o[13]);

    // R7
    tmr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> tmr == TMR_W'($past(tmr) + 1'b1));

    // R7
    tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(tmr));

    // R4
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 4'h0 && !ovf && !evt_any)
        |=> (sts & $past(wdata_i)) == 16'h0);

    // R6
    sci_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sci_o == |(sts & en & 16'h0521));

    // R11
    sd_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shutdown_o |-> $past(wr_en_i && addr_i == 4'h4 && wdata_i[13] &&
                             wdata_i[11:10] == 2'd0));

    // R11
    sd_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 4'h4 && wdata_i[13] && wdata_i[11:10] == 2'd0)
        |=> shutdown_o);
endmodule

bind pm_event_block pm_event_block_chk #(.TMR_W(TMR_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .evt_any    (evt_gbl_i | evt_pwrbtn_i | evt_rtc_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ovf        (tmr_ovf),
    .tmr        (tmr_cnt),
    .sts        (st_q.sts),
    .en         (st_q.en),
    .rd_data_o  (rd_data_o),
    .sci_o      (sci_o),
    .shutdown_o (shutdown_o)
);

// File: tb/sim_pm_event_block.sv
module sim_pm_event_block;
    localparam int TW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 0, eg = 0, ep = 0, er = 0, wr = 0;
    logic [3:0] addr = 0;
    logic [15:0] wd = 0;
    logic [TW-1:0] rd;
    logic sci, sd;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [15:0] m_sts = 0, m_en = 0, m_ctl = 0;
    logic [TW-1:0] m_tmr = 0;
    logic m_sci = 0, m_sd = 0;

    always #5 clk = ~clk;

    pm_event_block #(.TMR_W(TW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .evt_gbl_i(eg),
        .evt_pwrbtn_i(ep), .evt_rtc_i(er), .wr_en_i(wr), .addr_i(addr),
        .wdata_i(wd), .rd_data_o(rd), .sci_o(sci), .shutdown_o(sd));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return TW'(m_sts);
            4'h2: return TW'(m_en);
            4'h4: return TW'(m_ctl);
            4'h8: return m_tmr;
            default: return '0;
        endcase
    endfunction

    task automatic cyc(input logic t, input logic g, input logic p, input logic r,
                       input logic w, input logic [3:0] a, input logic [15:0] d,
                       input string req);
        logic [TW-1:0] nt;
        logic ov;
        @(negedge clk);
        tick = t; eg = g; ep = p; er = r; wr = w; addr = a; wd = d;
        nt = t ? TW'(m_tmr + 1'b1) : m_tmr;
        ov = nt[TW-1] ^ m_tmr[TW-1];
        if (w && a == 4'h0) m_sts = m_sts & ~d;
        if (ov) m_sts[0]  = 1'b1;
        if (g)  m_sts[5]  = 1'b1;
        if (p)  m_sts[8]  = 1'b1;
        if (r)  m_sts[10] = 1'b1;
        if (w && a == 4'h2) m_en = d;
        if (w && a == 4'h4) m_ctl = d & ~16'h2000;
        m_sd = w && a == 4'h4 && d[13] && d[11:10] == 2'd0;
        m_tmr = nt;
        m_sci = |(m_sts & m_en & 16'h0521);
        @(posedge clk); #1;
        tick = 0; eg = 0; ep = 0; er = 0; wr = 0;
        chk({req, " R6 sci"}, 32'(sci), 32'(m_sci));
        chk({req, " R11 shutdown"}, 32'(sd), 32'(m_sd));
    endtask

    task automatic rd_chk(input logic [3:0] a, input string req);
        addr = a; #1;
        chk({req, " read"}, 32'(rd), 32'(m_read(a)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R2: reset state
        chk("R2 sci", 32'(sci), 0);
        chk("R2 shutdown", 32'(sd), 0);
        rd_chk(4'h0, "R2 sts"); rd_chk(4'h2, "R2 en");
        rd_chk(4'h4, "R2 ctl"); rd_chk(4'h8, "R2 tmr");

        // R5 enable register, R3 power button event, R6 interrupt
        cyc(0,0,0,0,1,4'h2,16'hFFFF,"R5"); rd_chk(4'h2, "R5 en");
        cyc(0,0,1,0,0,4'h0,16'h0,"R3 pwrbtn"); rd_chk(4'h0, "R3 sts");
        cyc(0,1,0,1,0,4'h0,16'h0,"R3 gbl rtc"); rd_chk(4'h0, "R3 sts");
        // R4 zero write keeps, one write clears
        cyc(0,0,0,0,1,4'h0,16'h0000,"R4 zero"); rd_chk(4'h0, "R4 sts");
        cyc(0,0,0,0,1,4'h0,16'h0100,"R4 one"); rd_chk(4'h0, "R4 sts");
        // R3 set wins over clear
        cyc(0,1,0,0,1,4'h0,16'h0020,"R3 setwins"); rd_chk(4'h0, "R3 sts");
        cyc(0,0,0,0,1,4'h0,16'hFFFF,"R4 all"); rd_chk(4'h0, "R4 sts");
        // R6 mask: event with bit disabled gives no interrupt
        cyc(0,0,0,0,1,4'h2,16'hFADE,"R6 en"); 
        cyc(0,0,1,0,0,4'h0,16'h0,"R6 masked"); rd_chk(4'h0, "R6 sts");
        // R10 control store, R11 shutdown decode
        cyc(0,0,0,0,1,4'h4,16'hF3FF,"R11 sd"); rd_chk(4'h4, "R10 ctl");
        cyc(0,0,0,0,1,4'h4,16'h2400,"R11 typ1"); rd_chk(4'h4, "R10 ctl");
        cyc(0,0,0,0,1,4'h4,16'h03FF,"R11 noen"); rd_chk(4'h4, "R10 ctl");
        // R1 unmapped and timer writes ignored
        cyc(0,0,0,0,1,4'h6,16'h1234,"R1 ofs6");
        rd_chk(4'h6, "R1 ofs6"); rd_chk(4'h2, "R1 en"); rd_chk(4'h4, "R1 ctl");
        cyc(1,0,0,0,1,4'h8,16'hFFFF,"R1 tmrwr"); rd_chk(4'h8, "R1 tmr");
        cyc(0,0,0,0,1,4'hF,16'hFFFF,"R1 ofsF"); rd_chk(4'h0, "R1 sts");

        // R7 R8: run to first top-bit toggle, check every cycle
        cyc(0,0,0,0,1,4'h0,16'hFFFF,"R9 clr");
        while (m_tmr != TW'(1 << (TW-1))) begin
            cyc(1,0,0,0,0,4'h0,16'h0,"R8 run");
            if (m_tmr[TW-1] || m_tmr[7:0] == 8'h00) rd_chk(4'h0, "R8 ovf");
        end
        rd_chk(4'h8, "R7 tmr");
        // R9: cleared bit stays clear until next toggle
        cyc(1,0,0,0,1,4'h0,16'h0001,"R9 clr");
        rd_chk(4'h0, "R9 sts");
        while (m_tmr != '1) begin
            cyc(1,0,0,0,0,4'h0,16'h0,"R9 run");
            if (m_tmr[7:0] == 8'h00) rd_chk(4'h0, "R9 sts");
        end
        rd_chk(4'h0, "R9 quiet");
        // R8 R3: clear on the wrapping tick loses to overflow set
        cyc(1,0,0,0,1,4'h0,16'h0001,"R8 wrap");
        rd_chk(4'h0, "R8 wrap sts"); rd_chk(4'h8, "R7 wrap tmr");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            logic [15:0] d;
            case ($urandom_range(0, 5))
                0: a = 4'h0; 1: a = 4'h2; 2: a = 4'h4; 3: a = 4'h8;
                default: a = 4'($urandom);
            endcase
            d = 16'($urandom);
            if ($urandom_range(0, 3) == 0) d[13:10] = 4'b1000;
            cyc(1'($urandom), $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
                $urandom_range(0, 15) == 0, $urandom_range(0, 2) == 0, a, d, "R4 R5 R10 rnd");
            rd_chk(4'($urandom), "R1 R7 rnd");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule